// File: doc/BRIEF.md
# Banked Memory Window Controller

This block sits on a processor's 16-bit address bus and turns each request into one chip select plus, for the banked ROM region, a translated ROM address. A single byte-wide bank-control register steers the decode. One field picks which of two memories answers in a small window at the bottom of the address space: work RAM or palette RAM. Another field drives a level output. When that output is high, the video subsystem returns character ROM data through its video RAM window. A four-bit field selects one of sixteen 8 KB ROM pages, and that page appears in a fixed 8 KB CPU window.

The register is written through a simple write-enable port and is cleared by reset. The decode is combinational from the current register value and the CPU address. A value written at a clock edge therefore governs every access presented from the next cycle on.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset the register reads as zero. A request in 0x0000-0x03FF selects work RAM, `chr_readback` is low, and a request in the banked window maps to page 0 (ROM address 0x10000 + CPU address bits 12:0).
- R2: With register bit 5 low, a request (`cpu_req` high) in 0x0000-0x03FF asserts `cs_wram` only.
- R3: With register bit 5 high, a request in 0x0000-0x03FF asserts `cs_pal` only.
- R4: `chr_readback` equals register bit 6 and is independent of the address and of `cpu_req`.
- R5: A request in 0x6000-0x7FFF asserts `cs_rom_bank`. `rom_addr` is then 0x10000 + page*0x2000 + CPU address bits 12:0, where page is register bits 3:0.
- R6: At most one chip select is high in any cycle. An address outside both windows, or `cpu_req` low, asserts none.
- R7: A write with `ctl_we` high is captured at the rising clock edge. The cycle in which the write is presented still decodes with the old value, and the new value governs from the next cycle. Without a write the outputs for a given address do not change.
- R8: Register bits 7 and 4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Bank-control register write enable |
| ctl_wdata | input | 8 | Bank-control register write data |
| cpu_req | input | 1 | CPU access request qualifier |
| cpu_addr | input | 16 | CPU address |
| cs_wram | output | 1 | Work RAM select (low window) |
| cs_pal | output | 1 | Palette RAM select (low window) |
| cs_rom_bank | output | 1 | Banked ROM select |
| rom_addr | output | 18 | Translated ROM byte address |
| chr_readback | output | 1 | Character ROM readback enable |

## Verification
A register write and a CPU access can land in the same cycle. The access must decode with the old register value, and the new value must apply only from the following cycle. The bench provokes this on purpose. It presents writes that flip the palette select, the readback bit and the page together with accesses to the low window and the banked window. It judges each cycle's chip selects, ROM address and readback level against a bench model whose register copy is updated only after the clock edge. Random write/access mixes repeat the collision many times.

// File: rtl/bwin_pkg.sv
package bwin_pkg;

   typedef enum logic [1:0] {
      CS_WRAM = 2'd0,
      CS_PAL  = 2'd1,
      CS_BANK = 2'd2
   } cs_idx_e;

   localparam int NUM_CS = 3;

   function automatic logic in_window(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input int          size_log2);
      return (addr >> size_log2) == (base >> size_log2);
   endfunction

endpackage

// File: rtl/bwin_ctl_reg.sv
module bwin_ctl_reg #(
   parameter int CTL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/bwin_decode.sv
module bwin_decode
   import bwin_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int LOW_BASE  = 32'h0000,
   parameter int LOW_LOG2  = 10,
   parameter int BANK_BASE = 32'h6000,
   parameter int BANK_LOG2 = 13
) (
   input  logic              req,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pal_sel,
   output logic [NUM_CS-1:0] cs
);
   localparam int LOW_SIZE  = 1 << LOW_LOG2;
   localparam int BANK_SIZE = 1 << BANK_LOG2;

   if ((LOW_BASE % LOW_SIZE) != 0) begin : g_bad_low_align
      $error("low window base not aligned to its size");
   end
   if ((BANK_BASE % BANK_SIZE) != 0) begin : g_bad_bank_align
      $error("banked window base not aligned to its size");
   end
   if (!((LOW_BASE + LOW_SIZE <= BANK_BASE) || (BANK_BASE + BANK_SIZE <= LOW_BASE)))
   begin : g_bad_overlap
      $error("low and banked windows overlap");
   end
   if (BANK_BASE + BANK_SIZE > (1 << ADDR_W)) begin : g_bad_range
      $error("banked window exceeds address space");
   end

   logic hit_low, hit_bank;

   always_comb begin
      hit_low  = req && in_window(32'(addr), LOW_BASE, LOW_LOG2);
      hit_bank = req && in_window(32'(addr), BANK_BASE, BANK_LOG2);
      cs          = '0;
      cs[CS_WRAM] = hit_low && !pal_sel;
      cs[CS_PAL]  = hit_low &&  pal_sel;
      cs[CS_BANK] = hit_bank;
   end
endmodule

// File: rtl/bwin_xlate.sv
module bwin_xlate #(
   parameter int PAGE_BITS  = 4,
   parameter int PAGE_LOG2  = 13,
   parameter int ROM_BASE   = 32'h10000,
   parameter int ROM_ADDR_W = 18
) (
   input  logic [PAGE_BITS-1:0]  page,
   input  logic [PAGE_LOG2-1:0]  offset,
   output logic [ROM_ADDR_W-1:0] rom_addr
);
   localparam longint ROM_TOP = longint'(ROM_BASE) +
                                (longint'(1) << (PAGE_BITS + PAGE_LOG2));
   localparam int IDX_W = ROM_ADDR_W - PAGE_LOG2;

   if (ROM_TOP > (longint'(1) << ROM_ADDR_W)) begin : g_bad_fit
      $error("ROM address width too small for base plus all pages");
   end

   if ((ROM_BASE % (1 << PAGE_LOG2)) == 0) begin : g_aligned
      logic [IDX_W-1:0] idx;
      assign idx      = IDX_W'(ROM_BASE >> PAGE_LOG2) + IDX_W'(page);
      assign rom_addr = {idx, offset};
   end else begin : g_unaligned
      assign rom_addr = ROM_ADDR_W'(ROM_BASE) + ROM_ADDR_W'({page, offset});
   end
endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
   import bwin_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int CTL_W      = 8,
   parameter int PAL_BIT    = 5,
   parameter int RB_BIT     = 6,
   parameter int PAGE_LSB   = 0,
   parameter int PAGE_BITS  = 4,
   parameter int LOW_BASE   = 32'h0000,
   parameter int LOW_LOG2   = 10,
   parameter int BANK_BASE  = 32'h6000,
   parameter int PAGE_LOG2  = 13,
   parameter int ROM_BASE   = 32'h10000,
   parameter int ROM_ADDR_W = 18
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_we,
   input  logic [CTL_W-1:0]      ctl_wdata,
   input  logic                  cpu_req,
   input  logic [ADDR_W-1:0]     cpu_addr,
   output logic                  cs_wram,
   output logic                  cs_pal,
   output logic                  cs_rom_bank,
   output logic [ROM_ADDR_W-1:0] rom_addr,
   output logic                  chr_readback
);
   if (PAGE_LSB + PAGE_BITS > CTL_W || PAL_BIT >= CTL_W || RB_BIT >= CTL_W)
   begin : g_bad_field
      $error("control field outside register");
   end
   if (PAL_BIT == RB_BIT ||
       (PAL_BIT >= PAGE_LSB && PAL_BIT < PAGE_LSB + PAGE_BITS) ||
       (RB_BIT  >= PAGE_LSB && RB_BIT  < PAGE_LSB + PAGE_BITS)) begin : g_bad_overlap
      $error("control fields overlap");
   end

   logic [CTL_W-1:0]  ctl_q;
   logic [NUM_CS-1:0] cs_vec;
   logic              unused_ctl;

   bwin_ctl_reg #(.CTL_W(CTL_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_we),
      .wdata (ctl_wdata),
      .q     (ctl_q)
   );

   bwin_decode #(
      .ADDR_W   (ADDR_W),
      .LOW_BASE (LOW_BASE),
      .LOW_LOG2 (LOW_LOG2),
      .BANK_BASE(BANK_BASE),
      .BANK_LOG2(PAGE_LOG2)
   ) u_dec (
      .req     (cpu_req),
      .addr    (cpu_addr),
      .pal_sel (ctl_q[PAL_BIT]),
      .cs      (cs_vec)
   );

   bwin_xlate #(
      .PAGE_BITS (PAGE_BITS),
      .PAGE_LOG2 (PAGE_LOG2),
      .ROM_BASE  (ROM_BASE),
      .ROM_ADDR_W(ROM_ADDR_W)
   ) u_xl (
      .page     (ctl_q[PAGE_LSB +: PAGE_BITS]),
      .offset   (cpu_addr[PAGE_LOG2-1:0]),
      .rom_addr (rom_addr)
   );

   assign cs_wram      = cs_vec[CS_WRAM];
   assign cs_pal       = cs_vec[CS_PAL];
   assign cs_rom_bank  = cs_vec[CS_BANK];
   assign chr_readback = ctl_q[RB_BIT];
   assign unused_ctl   = ^ctl_q;
endmodule

// File: rtl/bwin_checker.sv
module bwin_checker #(
   parameter int ADDR_W     = 16,
   parameter int CTL_W      = 8,
   parameter int ROM_ADDR_W = 18
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ctl_we,
   input logic [CTL_W-1:0]      ctl_wdata,
   input logic                  cpu_req,
   input logic [ADDR_W-1:0]     cpu_addr,
   input logic                  cs_wram,
   input logic                  cs_pal,
   input logic                  cs_rom_bank,
   input logic [ROM_ADDR_W-1:0] rom_addr,
   input logic                  chr_readback
);
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_wram, cs_pal, cs_rom_bank})); // R6
   AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |-> !(cs_wram || cs_pal || cs_rom_bank)); // R6
   AST_RB_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> chr_readback == $past(ctl_wdata[6])); // R4
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_we |=> $stable(chr_readback)); // R7
   AST_PAL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_pal |-> cpu_addr < 16'h0400); // R3
   AST_BANK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rom_bank |-> rom_addr[12:0] == cpu_addr[12:0]); // R5
endmodule

bind bank_window_ctrl bwin_checker #(
   .ADDR_W(ADDR_W), .CTL_W(CTL_W), .ROM_ADDR_W(ROM_ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
   .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cs_wram(cs_wram),
   .cs_pal(cs_pal), .cs_rom_bank(cs_rom_bank), .rom_addr(rom_addr),
   .chr_readback(chr_readback)
);

// File: tb/bank_window_ctrl_tb.sv
`timescale 1ns/1ps
module bank_window_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = '0;
   logic        cpu_req = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cs_wram, cs_pal, cs_rom_bank, chr_readback;
   logic [17:0] rom_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [7:0] mreg = 8'h00;

   always #2.5 clk = ~clk;

   bank_window_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cs_wram(cs_wram),
      .cs_pal(cs_pal), .cs_rom_bank(cs_rom_bank), .rom_addr(rom_addr),
      .chr_readback(chr_readback)
   );

   function automatic logic [2:0] exp_cs(input logic [7:0] r, input logic req,
                                         input logic [15:0] a);
      logic low, bank;
      low  = req && (a < 16'h0400);
      bank = req && (a >= 16'h6000) && (a <= 16'h7FFF);
      return {bank, low && r[5], low && !r[5]};
   endfunction

   function automatic logic [17:0] exp_rom(input logic [7:0] r, input logic [15:0] a);
      return 18'h10000 + 18'(r[3:0]) * 18'h2000 + 18'(a[12:0]);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic verify(input string tag);
      logic [2:0] e;
      e = exp_cs(mreg, cpu_req, cpu_addr);
      chk(tag, {29'b0, cs_rom_bank, cs_pal, cs_wram}, {29'b0, e});
      chk("R4 chr_readback", {31'b0, chr_readback}, {31'b0, mreg[6]});
      if (e[2]) chk("R5 rom_addr", {14'b0, rom_addr}, {14'b0, exp_rom(mreg, cpu_addr)});
   endtask

   // present inputs for one cycle, check against register value before the edge
   task automatic step(input logic we, input logic [7:0] wd, input logic req,
                       input logic [15:0] a, input string tag);
      @(negedge clk);
      ctl_we = we; ctl_wdata = wd; cpu_req = req; cpu_addr = a;
      #1 verify(tag);
      @(posedge clk);
      if (we) mreg = wd;
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      step(0, 8'h00, 1, 16'h0100, "R1 reset low window");
      step(0, 8'h00, 1, 16'h6123, "R1 reset bank page0");
      chk("R1 reset rom_addr", {14'b0, rom_addr}, 32'h10123);
      // R2/R3/R7: write palette select in same cycle as low-window access
      step(1, 8'h20, 1, 16'h03FF, "R7 old value during write");
      step(0, 8'h00, 1, 16'h03FF, "R3 palette selected");
      step(0, 8'h00, 1, 16'h0400, "R6 just above low window");
      step(1, 8'h00, 1, 16'h0000, "R7 palette still during write");
      step(0, 8'h00, 1, 16'h0000, "R2 work ram selected");
      // R4 readback
      step(1, 8'h40, 0, 16'h0000, "R6 idle no select");
      step(0, 8'h40, 0, 16'hFFFF, "R4 readback high idle");
      // R5 page 15 top
      step(1, 8'h0F, 1, 16'h7FFF, "R7 page change collision");
      step(0, 8'h00, 1, 16'h7FFF, "R5 page15 top");
      chk("R5 top rom_addr", {14'b0, rom_addr}, 32'h2FFFF);
      step(0, 8'h00, 1, 16'h5FFF, "R6 below bank window");
      step(0, 8'h00, 1, 16'h8000, "R6 above bank window");
      // R8 bits 7 and 4 ignored
      step(1, 8'h95, 1, 16'h6000, "R8 write ignored bits");
      step(0, 8'h00, 1, 16'h6000, "R8 ignored bits bank");
      chk("R8 rom_addr ignores bits7/4", {14'b0, rom_addr}, 32'h1A000);
      chk("R8 no palette from bit4", {31'b0, cs_wram}, 32'h0);
      step(0, 8'h00, 1, 16'h0010, "R8 low window wram");
      chk("R8 wram despite bit7/4", {31'b0, cs_wram}, 32'h1);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [1:0]  sel;
         sel = 2'($urandom_range(0, 3));
         case (sel)
            2'd0: a = 16'($urandom_range(0, 16'h03FF));
            2'd1: a = 16'($urandom_range(16'h6000, 16'h7FFF));
            default: a = 16'($urandom);
         endcase
         step(($urandom_range(0, 3) == 0), 8'($urandom), ($urandom_range(0, 7) != 0),
              a, "R6 R7 random decode");
      end
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule